// File: doc/BRIEF.md
# Reversible Carry-Select Adder

This block adds two N-bit operands and a carry-in using only reversible primitives. Each full adder is a single 4x4 dual Peres gate with one input tied to 0 and the carry arriving on the fourth input. Two ripple chains of these gates run side by side. One chain has its carry-in held at 0 and the other has it held at 1. Operand bits are not wired to both chains directly. Each bit is duplicated by a Feynman copy gate, because plain fan-out is not reversible.

The real carry-in then chooses between the two precomputed results. It does this through a row of Fredkin controlled-swap gates, with one gate per sum bit and one for the carry-out. The select line passes from one Fredkin gate to the next through each gate's pass-through output, so it is never fanned out either.

Every unused gate output leaves the block on a garbage bus, so the complete reversible state can be seen at the ports. The block also reports three counts as constant outputs that follow from the width: the number of gates, the number of constant inputs and the number of garbage lines. The block is purely combinational. A result is settled after one ripple chain plus one Fredkin level.

Top module: `rev_csel_adder`

## Requirements
- R1: For every a, b and cin, {cout, sum} equals a + b + cin as an unsigned (N+1)-bit value.
- R2: For each bit i, the adder garbage carries the Peres pass-through outputs of both chains. Bit 2i holds a[i] and bit 2i+1 holds a[i] xor b[i]. The carry-in-0 chain occupies bits [2N-1:0] and the carry-in-1 chain occupies bits [4N-1:2N].
- R3: Select garbage bits [N:0] hold the result that was not selected, with bit N as its carry. This value equals a + b + (not cin).
- R4: Select garbage bit N+1 equals cin, because the select line emerges unchanged from the last Fredkin gate.
- R5: gateCount reports 5N+1. This is 2N dual Peres gates, 2N Feynman copy gates and N+1 Fredkin gates.
- R6: constCount reports 4N+2. This is one tied input per dual Peres gate, one per Feynman copy gate, and the two chain carry-ins.
- R7: garbageCount reports 5N+2, which equals the total width of both garbage buses.
- R8: The behaviour of R1 to R7 holds for any WIDTH. It is checked exhaustively at 4 bits and with random vectors at 8 and 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry-in; also drives the Fredkin select |
| sum | output | WIDTH | Selected sum |
| cout | output | 1 | Selected carry-out |
| adderGarbage | output | 4*WIDTH | Pass-through outputs of every dual Peres gate |
| selGarbage | output | WIDTH+2 | Unselected result and the final select line |
| gateCount | output | CNT_W | Reversible gate count |
| constCount | output | CNT_W | Constant input count |
| garbageCount | output | CNT_W | Garbage output count |

## Verification
A broken chain or a miswired operand copy makes one of two results wrong: the selected one shows up on sum and cout, and the other on selGarbage. Because both results are visible at the ports, a fault in either chain appears on the same input vector, whatever the level of cin. A faulty select path shows up in two ways: the outputs for both values of cin are swapped, or bit N+1 of selGarbage disagrees with cin. The block holds no state, so every error appears within the combinational settling time of the vector that exposes it.

// File: rtl/rev_csel_pkg.sv
package rev_csel_pkg;

  typedef struct packed {
    logic selLine;
    logic tieLow;
    logic tieHigh;
  } selStrobes_t;

  function automatic int gatesFor(input int n);
    return 5 * n + 1;
  endfunction

  function automatic int constsFor(input int n);
    return 4 * n + 2;
  endfunction

  function automatic int garbageFor(input int n);
    return 5 * n + 2;
  endfunction

endpackage

// File: rtl/rev_gates.sv
module rev_feynman_gate (
  input  logic inA,
  input  logic inB,
  output logic outP,
  output logic outQ
);
  assign outP = inA;
  assign outQ = inA ^ inB;
endmodule

module rev_dual_peres_gate (
  input  logic inA,
  input  logic inB,
  input  logic inC,
  input  logic inD,
  output logic outP,
  output logic outQ,
  output logic outR,
  output logic outS
);
  logic axb;
  assign axb  = inA ^ inB;
  assign outP = inA;
  assign outQ = axb;
  assign outR = axb ^ inD;
  assign outS = (axb & inD) ^ (inA & inB) ^ inC;
endmodule

module rev_fredkin_gate (
  input  logic inA,
  input  logic inB,
  input  logic inC,
  output logic outP,
  output logic outQ,
  output logic outR
);
  assign outP = inA;
  assign outQ = (~inA & inB) ^ (inA & inC);
  assign outR = (~inA & inC) ^ (inA & inB);
endmodule

// File: rtl/rev_csel_ctrl.sv
module rev_csel_ctrl
  import rev_csel_pkg::*;
(
  input  logic        cin,
  output selStrobes_t strobes
);
  always_comb begin
    strobes.selLine = cin;
    strobes.tieLow  = 1'b0;
    strobes.tieHigh = 1'b1;
  end
endmodule

// File: rtl/rev_csel_datapath.sv
module rev_csel_datapath
  import rev_csel_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]   a,
  input  logic [WIDTH-1:0]   b,
  input  selStrobes_t        strobes,
  output logic [WIDTH-1:0]   sum,
  output logic               cout,
  output logic [4*WIDTH-1:0] adderGarbage,
  output logic [WIDTH+1:0]   selGarbage
);
  localparam int NCH = 2;

  logic [WIDTH-1:0] aCopy [NCH];
  logic [WIDTH-1:0] bCopy [NCH];
  logic [WIDTH:0]   chainCarry [NCH];
  logic [WIDTH-1:0] chainSum [NCH];
  logic [WIDTH+1:0] selPass;
  logic [WIDTH:0]   selOut;

  genvar i, ch;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_copy
      rev_feynman_gate u_copyA (
        .inA(a[i]), .inB(strobes.tieLow),
        .outP(aCopy[0][i]), .outQ(aCopy[1][i]));
      rev_feynman_gate u_copyB (
        .inA(b[i]), .inB(strobes.tieLow),
        .outP(bCopy[0][i]), .outQ(bCopy[1][i]));
    end

    for (ch = 0; ch < NCH; ch++) begin : g_chain
      if (ch == 0) begin : g_cin0
        assign chainCarry[ch][0] = strobes.tieLow;
      end else begin : g_cin1
        assign chainCarry[ch][0] = strobes.tieHigh;
      end
      for (i = 0; i < WIDTH; i++) begin : g_bit
        rev_dual_peres_gate u_fa (
          .inA(aCopy[ch][i]), .inB(bCopy[ch][i]),
          .inC(strobes.tieLow), .inD(chainCarry[ch][i]),
          .outP(adderGarbage[ch*2*WIDTH + 2*i]),
          .outQ(adderGarbage[ch*2*WIDTH + 2*i + 1]),
          .outR(chainSum[ch][i]),
          .outS(chainCarry[ch][i+1]));
      end
    end

    assign selPass[0] = strobes.selLine;
    for (i = 0; i <= WIDTH; i++) begin : g_sel
      logic loVal, hiVal;
      if (i < WIDTH) begin : g_sumSel
        assign loVal = chainSum[0][i];
        assign hiVal = chainSum[1][i];
      end else begin : g_carrySel
        assign loVal = chainCarry[0][WIDTH];
        assign hiVal = chainCarry[1][WIDTH];
      end
      rev_fredkin_gate u_mux (
        .inA(selPass[i]), .inB(loVal), .inC(hiVal),
        .outP(selPass[i+1]), .outQ(selOut[i]), .outR(selGarbage[i]));
    end
  endgenerate

  assign selGarbage[WIDTH+1] = selPass[WIDTH+1];
  assign sum  = selOut[WIDTH-1:0];
  assign cout = selOut[WIDTH];
endmodule

// File: rtl/rev_csel_adder.sv
module rev_csel_adder
  import rev_csel_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int CNT_W = 16
) (
  input  logic [WIDTH-1:0]   a,
  input  logic [WIDTH-1:0]   b,
  input  logic               cin,
  output logic [WIDTH-1:0]   sum,
  output logic               cout,
  output logic [4*WIDTH-1:0] adderGarbage,
  output logic [WIDTH+1:0]   selGarbage,
  output logic [CNT_W-1:0]   gateCount,
  output logic [CNT_W-1:0]   constCount,
  output logic [CNT_W-1:0]   garbageCount
);
  localparam int GATES   = gatesFor(WIDTH);
  localparam int CONSTS  = constsFor(WIDTH);
  localparam int GARBAGE = garbageFor(WIDTH);

  selStrobes_t strobes;

  rev_csel_ctrl u_ctrl (
    .cin(cin),
    .strobes(strobes));

  rev_csel_datapath #(.WIDTH(WIDTH)) u_dp (
    .a(a), .b(b), .strobes(strobes),
    .sum(sum), .cout(cout),
    .adderGarbage(adderGarbage), .selGarbage(selGarbage));

  assign gateCount    = CNT_W'(GATES);
  assign constCount   = CNT_W'(CONSTS);
  assign garbageCount = CNT_W'(GARBAGE);
endmodule

// File: rtl/rev_csel_adder_chk.sv
module rev_csel_adder_chk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0]   a,
  input logic [WIDTH-1:0]   b,
  input logic               cin,
  input logic [WIDTH-1:0]   sum,
  input logic               cout,
  input logic [4*WIDTH-1:0] adderGarbage,
  input logic [WIDTH+1:0]   selGarbage
);
  logic [WIDTH:0] refSel, refOther;

  always_comb begin
    refSel   = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
    refOther = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, ~cin};
    if (!$isunknown({a, b, cin})) begin
      // R1
      add_result_chk: assert ({cout, sum} == refSel);
      // R3
      other_result_chk: assert (selGarbage[WIDTH:0] == refOther);
      // R4
      sel_pass_chk: assert (selGarbage[WIDTH+1] == cin);
      // R2
      copy_lo_chk: assert (adderGarbage[2*WIDTH-1:0] == adderGarbage[4*WIDTH-1:2*WIDTH]);
      // R2
      pass_a_chk: assert (adderGarbage[0] == a[0] && adderGarbage[1] == (a[0] ^ b[0]));
    end
  end
endmodule

bind rev_csel_adder rev_csel_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout),
  .adderGarbage(adderGarbage), .selGarbage(selGarbage));

// File: tb/rev_csel_adder_tb_top.sv
`timescale 1ns/1ps
module rev_csel_adder_tb_top;
  localparam int N4 = 4;
  localparam int N8 = 8;
  localparam int N16 = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [N4-1:0] a4, b4;   logic c4;
  logic [N8-1:0] a8, b8;   logic c8;
  logic [N16-1:0] a16, b16; logic c16;

  logic [N4-1:0] s4;  logic co4;  logic [4*N4-1:0] ag4;  logic [N4+1:0] sg4;
  logic [N8-1:0] s8;  logic co8;  logic [4*N8-1:0] ag8;  logic [N8+1:0] sg8;
  logic [N16-1:0] s16; logic co16; logic [4*N16-1:0] ag16; logic [N16+1:0] sg16;
  logic [15:0] gc4, cc4, xc4, gc8, cc8, xc8, gc16, cc16, xc16;

  rev_csel_adder #(.WIDTH(N4)) dut4_i (
    .a(a4), .b(b4), .cin(c4), .sum(s4), .cout(co4),
    .adderGarbage(ag4), .selGarbage(sg4),
    .gateCount(gc4), .constCount(cc4), .garbageCount(xc4));
  rev_csel_adder #(.WIDTH(N8)) dut_i (
    .a(a8), .b(b8), .cin(c8), .sum(s8), .cout(co8),
    .adderGarbage(ag8), .selGarbage(sg8),
    .gateCount(gc8), .constCount(cc8), .garbageCount(xc8));
  rev_csel_adder #(.WIDTH(N16)) dut16_i (
    .a(a16), .b(b16), .cin(c16), .sum(s16), .cout(co16),
    .adderGarbage(ag16), .selGarbage(sg16),
    .gateCount(gc16), .constCount(cc16), .garbageCount(xc16));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] addRef(input logic [31:0] x, input logic [31:0] y, input logic c);
    return 64'(x) + 64'(y) + 64'(c);
  endfunction

  function automatic logic [63:0] passRef(input logic [31:0] x, input logic [31:0] y, input int n);
    logic [63:0] r = '0;
    for (int i = 0; i < n; i++) begin
      r[2*i]   = x[i];
      r[2*i+1] = x[i] ^ y[i];
    end
    return r;
  endfunction

  task automatic check4();
    check("R1 w4", 64'({co4, s4}), addRef(32'(a4), 32'(b4), c4));
    check("R3 w4", 64'(sg4[N4:0]), addRef(32'(a4), 32'(b4), ~c4));
    check("R4 w4", 64'(sg4[N4+1]), 64'(c4));
    check("R2 w4 lo", 64'(ag4[2*N4-1:0]), passRef(32'(a4), 32'(b4), N4));
    check("R2 w4 hi", 64'(ag4[4*N4-1:2*N4]), passRef(32'(a4), 32'(b4), N4));
  endtask

  task automatic check8();
    check("R1 w8", 64'({co8, s8}), addRef(32'(a8), 32'(b8), c8));
    check("R3 w8", 64'(sg8[N8:0]), addRef(32'(a8), 32'(b8), ~c8));
    check("R4 w8", 64'(sg8[N8+1]), 64'(c8));
    check("R2 w8 lo", 64'(ag8[2*N8-1:0]), passRef(32'(a8), 32'(b8), N8));
    check("R2 w8 hi", 64'(ag8[4*N8-1:2*N8]), passRef(32'(a8), 32'(b8), N8));
  endtask

  task automatic check16();
    check("R1 w16", 64'({co16, s16}), addRef(32'(a16), 32'(b16), c16));
    check("R3 w16", 64'(sg16[N16:0]), addRef(32'(a16), 32'(b16), ~c16));
    check("R4 w16", 64'(sg16[N16+1]), 64'(c16));
    check("R2 w16 lo", 64'(ag16[2*N16-1:0]), passRef(32'(a16), 32'(b16), N16));
    check("R2 w16 hi", 64'(ag16[4*N16-1:2*N16]), passRef(32'(a16), 32'(b16), N16));
  endtask

  task automatic drive8(input logic [N8-1:0] x, input logic [N8-1:0] y, input logic c);
    @(posedge clk); a8 = x; b8 = y; c8 = c;
    @(negedge clk); check8();
  endtask

  task automatic drive16(input logic [N16-1:0] x, input logic [N16-1:0] y, input logic c);
    @(posedge clk); a16 = x; b16 = y; c16 = c;
    @(negedge clk); check16();
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finishRun();
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed_0c5a;
    void'($urandom(seed));
    a4 = '0; b4 = '0; c4 = 1'b0;
    a8 = '0; b8 = '0; c8 = 1'b0;
    a16 = '0; b16 = '0; c16 = 1'b0;
    @(negedge clk);
    // Quiescent state with all inputs at zero (R1)
    check("R1 idle w8", 64'({co8, s8}), 64'd0);
    check("R3 idle w8", 64'(sg8[N8:0]), 64'd1);
    // R5 R6 R7 count report, R8 across widths
    check("R5 w4", 64'(gc4), 64'(5*N4+1));
    check("R6 w4", 64'(cc4), 64'(4*N4+2));
    check("R7 w4", 64'(xc4), 64'(5*N4+2));
    check("R5 w8", 64'(gc8), 64'(5*N8+1));
    check("R6 w8", 64'(cc8), 64'(4*N8+2));
    check("R7 w8", 64'(xc8), 64'(5*N8+2));
    check("R5 w16", 64'(gc16), 64'(5*N16+1));
    check("R6 w16", 64'(cc16), 64'(4*N16+2));
    check("R7 w16", 64'(xc16), 64'(5*N16+2));
    check("R7 width w8", 64'($bits(ag8) + $bits(sg8)), 64'(xc8));

    // R8 exhaustive at 4 bits
    for (int v = 0; v < 512; v++) begin
      @(posedge clk);
      a4 = v[3:0]; b4 = v[7:4]; c4 = v[8];
      @(negedge clk);
      check4();
    end

    // Directed corners at 8 and 16 bits (R1 full carry ripple)
    drive8(8'hFF, 8'h00, 1'b1);
    drive8(8'hFF, 8'hFF, 1'b1);
    drive8(8'hFF, 8'hFF, 1'b0);
    drive8(8'h80, 8'h80, 1'b0);
    drive8(8'h55, 8'hAA, 1'b1);
    drive16(16'hFFFF, 16'h0000, 1'b1);
    drive16(16'hFFFF, 16'hFFFF, 1'b1);
    drive16(16'h8000, 16'h8000, 1'b0);

    // R8 random vectors
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] r;
      r = $urandom();
      drive8(r[7:0], r[15:8], r[16]);
      drive16(r[31:16], 16'($urandom()), r[17]);
    end

    done = 1'b1;
    finishRun();
  end
endmodule